// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor, built as a microprogrammed engine. It keeps a control address register and a control buffer register. It also holds a 32-word control store, which is a ROM computed inside the module. Each word has three parts: one bit for each datapath control signal, a 3-bit condition code, and a target address.

Every clock is one micro-operation. On that edge the buffer register takes the word at the new control address, and its signal bits appear on `ctrl` for the whole cycle. At the same time the sequencer works out the following address. That address is one of three things:
- the current address plus one;
- the word's target, when the selected condition holds;
- the entry of the routine for the current opcode.

The store holds the following routines:
- an instruction fetch;
- an execute entry, which tests for an indirect operand and then dispatches on the opcode;
- an indirect-operand routine;
- an interrupt-entry routine;
- the opcode routines.

Every opcode routine returns through a shared check word at the last address. That word goes to the interrupt routine when a request is pending. Otherwise its increment wraps the address to the first fetch word.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high, `ctrl` is all zero. On the first cycle after `rst` falls, `ctrl` shows the first fetch word, which has only bit 0 set.
- R2: Fetch is four cycles, each with the `ctrl` value shown below. After the fourth cycle the unit goes unconditionally to the execute entry.
  - cycle 1: bit 0.
  - cycle 2: bits 5 and 9.
  - cycle 3: bits 12 and 13.
  - cycle 4: bit 15.
- R3: A word whose condition is "none", or whose condition tests false, is followed by the word at the next address.
- R4: The execute entry (empty `ctrl`) checks `ind_bit`.
  - With `ind_bit` high, the unit runs the indirect routine: bit 2, then bit 5.
  - It then reaches the dispatch word (empty `ctrl`).
  - With `ind_bit` low, the unit goes straight to the dispatch word.
- R5: The dispatch word jumps on the `opcode` sampled in that cycle. Each routine is listed by its `ctrl` values in order.
  - 1 = load: {1}, {5}, {14}.
  - 2 = add: {1}, {5}, {10, 13}.
  - 3 = and: {1}, {5}, {11, 13}.
  - 4 = store: {1}, {8}, {6}.
  - 5 = jump: {16}.
  - 6 = jump-if-zero.
  - 0 and 7 = no operation. These go directly to the check word.
- R6: The jump-if-zero routine opens with an empty word that tests `zero_flag`.
  - With the flag high, it continues with the jump word (bit 16).
  - With the flag low, it continues with one empty word.
- R7: Every opcode routine ends at the check word (empty `ctrl`).
  - If `irq` is high in that cycle, the interrupt routine follows.
  - Otherwise the first fetch word follows.
- R8: The interrupt routine runs these `ctrl` values in order: {3, 7}, {6}, {4}, {5}, {17}. It then returns to the first fetch word.
- R9: `ctrl` bit map:

  | Bit | Signal |
  |---|---|
  | 0 | MAR from PC |
  | 1 | MAR from IR address |
  | 2 | MAR from MBR |
  | 3 | MAR from SP |
  | 4 | MAR from interrupt vector |
  | 5 | memory read |
  | 6 | memory write |
  | 7 | MBR from PC |
  | 8 | MBR from AC |
  | 9 | ALU increment |
  | 10 | ALU add |
  | 11 | ALU and |
  | 12 | IR from MBR |
  | 13 | AC from ALU |
  | 14 | AC from MBR |
  | 15 | PC from AC |
  | 16 | PC from IR address |
  | 17 | PC from MBR |

- R10: `irq`, `zero_flag`, `ind_bit` and `opcode` have no effect in any cycle whose word does not test them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one micro-operation per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W | Opcode field of the instruction register |
| ind_bit | input | 1 | Indirect-addressing bit of the instruction |
| zero_flag | input | 1 | ALU zero flag |
| irq | input | 1 | Pending interrupt request |
| ctrl | output | 18 | Control-signal vector |

## Verification
Two decisions can meet in one cycle. The first is a jump-if-zero word that sees a true zero flag while an interrupt request is already high. The second is an execute entry that sees the indirect bit together with an opcode that would dispatch. The stimulus drives random opcode, flag, indirect and request values on every cycle, so these overlaps recur many times. The behavioural model advances by routine name and step. It expects the request to be honoured only at the check word, and the opcode only at the dispatch word. Any early jump, or any lost jump, shows up as a `ctrl` mismatch in the following cycle.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter  int ADDR_W = 5,
  parameter  int OP_W   = 3,
  localparam int SIG_W  = 18,
  localparam int COND_W = 3,
  localparam int WORD_W = SIG_W + COND_W + ADDR_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic             ind_bit,
  input  logic             zero_flag,
  input  logic             irq,
  output logic [SIG_W-1:0] ctrl
);

  localparam logic [COND_W-1:0] C_NONE = 3'd0;
  localparam logic [COND_W-1:0] C_JMP  = 3'd1;
  localparam logic [COND_W-1:0] C_ZERO = 3'd2;
  localparam logic [COND_W-1:0] C_IRQ  = 3'd3;
  localparam logic [COND_W-1:0] C_DISP = 3'd4;
  localparam logic [COND_W-1:0] C_IND  = 3'd5;

  localparam int A_FETCH = 0;
  localparam int A_EXEC  = 4;
  localparam int A_DISP  = 5;
  localparam int A_IND   = 6;
  localparam int A_INT   = 8;
  localparam int A_LOAD  = 13;
  localparam int A_ADD   = 16;
  localparam int A_AND   = 19;
  localparam int A_STORE = 22;
  localparam int A_JMP   = 25;
  localparam int A_JZ    = 26;
  localparam int A_CHK   = DEPTH - 1;

  localparam int S_MAR_PC  = 0;
  localparam int S_MAR_IR  = 1;
  localparam int S_MAR_MBR = 2;
  localparam int S_MAR_SP  = 3;
  localparam int S_MAR_VEC = 4;
  localparam int S_MEM_RD  = 5;
  localparam int S_MEM_WR  = 6;
  localparam int S_MBR_PC  = 7;
  localparam int S_MBR_AC  = 8;
  localparam int S_ALU_INC = 9;
  localparam int S_ALU_ADD = 10;
  localparam int S_ALU_AND = 11;
  localparam int S_IR_MBR  = 12;
  localparam int S_AC_ALU  = 13;
  localparam int S_AC_MBR  = 14;
  localparam int S_PC_AC   = 15;
  localparam int S_PC_IR   = 16;
  localparam int S_PC_MBR  = 17;

  function automatic logic [SIG_W-1:0] sb(input int i);
    return SIG_W'(1) << i;
  endfunction

  function automatic logic [WORD_W-1:0] mk(input logic [SIG_W-1:0] s,
                                           input logic [COND_W-1:0] c,
                                           input int a);
    return {ADDR_W'(a), c, s};
  endfunction

  function automatic logic [WORD_W-1:0] rom(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = '0;
    case (int'(a))
      A_FETCH:     w = mk(sb(S_MAR_PC), C_NONE, 0);
      A_FETCH + 1: w = mk(sb(S_MEM_RD) | sb(S_ALU_INC), C_NONE, 0);
      A_FETCH + 2: w = mk(sb(S_IR_MBR) | sb(S_AC_ALU), C_NONE, 0);
      A_FETCH + 3: w = mk(sb(S_PC_AC), C_JMP, A_EXEC);
      A_EXEC:      w = mk('0, C_IND, A_IND);
      A_DISP:      w = mk('0, C_DISP, 0);
      A_IND:       w = mk(sb(S_MAR_MBR), C_NONE, 0);
      A_IND + 1:   w = mk(sb(S_MEM_RD), C_JMP, A_DISP);
      A_INT:       w = mk(sb(S_MBR_PC) | sb(S_MAR_SP), C_NONE, 0);
      A_INT + 1:   w = mk(sb(S_MEM_WR), C_NONE, 0);
      A_INT + 2:   w = mk(sb(S_MAR_VEC), C_NONE, 0);
      A_INT + 3:   w = mk(sb(S_MEM_RD), C_NONE, 0);
      A_INT + 4:   w = mk(sb(S_PC_MBR), C_JMP, A_FETCH);
      A_LOAD:      w = mk(sb(S_MAR_IR), C_NONE, 0);
      A_LOAD + 1:  w = mk(sb(S_MEM_RD), C_NONE, 0);
      A_LOAD + 2:  w = mk(sb(S_AC_MBR), C_JMP, A_CHK);
      A_ADD:       w = mk(sb(S_MAR_IR), C_NONE, 0);
      A_ADD + 1:   w = mk(sb(S_MEM_RD), C_NONE, 0);
      A_ADD + 2:   w = mk(sb(S_ALU_ADD) | sb(S_AC_ALU), C_JMP, A_CHK);
      A_AND:       w = mk(sb(S_MAR_IR), C_NONE, 0);
      A_AND + 1:   w = mk(sb(S_MEM_RD), C_NONE, 0);
      A_AND + 2:   w = mk(sb(S_ALU_AND) | sb(S_AC_ALU), C_JMP, A_CHK);
      A_STORE:     w = mk(sb(S_MAR_IR), C_NONE, 0);
      A_STORE + 1: w = mk(sb(S_MBR_AC), C_NONE, 0);
      A_STORE + 2: w = mk(sb(S_MEM_WR), C_JMP, A_CHK);
      A_JMP:       w = mk(sb(S_PC_IR), C_JMP, A_CHK);
      A_JZ:        w = mk('0, C_ZERO, A_JMP);
      A_JZ + 1:    w = mk('0, C_JMP, A_CHK);
      A_CHK:       w = mk('0, C_IRQ, A_INT);
      default:     w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] dispatch(input logic [OP_W-1:0] op);
    int a;
    case (int'(op))
      1:       a = A_LOAD;
      2:       a = A_ADD;
      3:       a = A_AND;
      4:       a = A_STORE;
      5:       a = A_JMP;
      6:       a = A_JZ;
      default: a = A_CHK;
    endcase
    return ADDR_W'(a);
  endfunction

  logic [ADDR_W-1:0] car, nxt, inc;
  logic [WORD_W-1:0] cbr;
  logic [SIG_W-1:0]  cbr_sig;
  logic [COND_W-1:0] cbr_cond;
  logic [ADDR_W-1:0] cbr_addr;

  assign {cbr_addr, cbr_cond, cbr_sig} = cbr;
  assign inc = car + 1'b1;

  always_comb begin
    case (cbr_cond)
      C_JMP:   nxt = cbr_addr;
      C_ZERO:  nxt = zero_flag ? cbr_addr : inc;
      C_IRQ:   nxt = irq ? cbr_addr : inc;
      C_DISP:  nxt = dispatch(opcode);
      C_IND:   nxt = ind_bit ? cbr_addr : inc;
      default: nxt = inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= ADDR_W'(A_FETCH);
      cbr <= rom(ADDR_W'(A_FETCH));
    end else begin
      car <= nxt;
      cbr <= rom(nxt);
    end
  end

  assign ctrl = rst ? '0 : cbr_sig;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    cbr_cond == C_NONE |=> car == $past(car) + 1'b1); // R3
  AST_IND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (car == ADDR_W'(A_EXEC) && ind_bit) |=> car == ADDR_W'(A_IND)); // R4
  AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (car == ADDR_W'(A_JZ) && zero_flag) |=> ctrl == sb(S_PC_IR)); // R6
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (car == ADDR_W'(A_CHK) && irq) |=> car == ADDR_W'(A_INT)); // R7
  AST_CHK_WRAP: assert property (@(posedge clk) disable iff (rst)
    (car == ADDR_W'(A_CHK) && !irq) |=> car == ADDR_W'(A_FETCH)); // R7
  AST_INT_RETURN: assert property (@(posedge clk) disable iff (rst)
    car == ADDR_W'(A_INT + 4) |=> ctrl == sb(S_MAR_PC)); // R8
  AST_ONE_MAR_SRC: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl[S_MAR_VEC:S_MAR_PC]) <= 1); // R9

endmodule

// File: tb/sim_ucode_sequencer.sv
`timescale 1ns/1ps
module sim_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  opcode;
  logic        ind_bit, zero_flag, irq;
  logic [17:0] ctrl;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  ucode_sequencer u0 (.clk(clk), .rst(rst), .opcode(opcode), .ind_bit(ind_bit),
                      .zero_flag(zero_flag), .irq(irq), .ctrl(ctrl));

  always #2.5 clk = ~clk;

  localparam int RF = 0, RX = 1, RI = 2, RQ = 3, RL = 4, RA = 5, RN = 6,
                 RS = 7, RJ = 8, RZ = 9, RC = 10;
  int rt, sp;

  function automatic logic [17:0] b(input int i);
    return 18'd1 << i;
  endfunction

  function automatic logic [17:0] expect_sig(input int r, input int s);
    case (r)
      RF: case (s) 0: return b(0); 1: return b(5) | b(9);
                   2: return b(12) | b(13); default: return b(15); endcase
      RI: return s == 0 ? b(2) : b(5);
      RQ: case (s) 0: return b(3) | b(7); 1: return b(6); 2: return b(4);
                   3: return b(5); default: return b(17); endcase
      RL: case (s) 0: return b(1); 1: return b(5); default: return b(14); endcase
      RA: case (s) 0: return b(1); 1: return b(5); default: return b(10) | b(13); endcase
      RN: case (s) 0: return b(1); 1: return b(5); default: return b(11) | b(13); endcase
      RS: case (s) 0: return b(1); 1: return b(8); default: return b(6); endcase
      RJ: return b(16);
      default: return 18'd0;
    endcase
  endfunction

  function automatic string req_name(input int r, input int s);
    case (r)
      RF: return s == 0 ? "R9" : "R2";
      RX, RI: return "R4";
      RZ: return "R6";
      RC: return "R7";
      RQ: return "R8";
      default: return s == 0 ? "R5" : "R3";
    endcase
  endfunction

  task automatic advance(input logic [2:0] op, input logic ind, input logic z, input logic rq);
    case (rt)
      RF: if (sp < 3) sp++; else begin rt = RX; sp = 0; end
      RX: if (sp == 0 && ind) begin rt = RI; sp = 0; end
          else if (sp == 0) sp = 1;
          else begin
            sp = 0;
            case (op)
              3'd1: rt = RL; 3'd2: rt = RA; 3'd3: rt = RN; 3'd4: rt = RS;
              3'd5: rt = RJ; 3'd6: rt = RZ; default: rt = RC;
            endcase
          end
      RI: if (sp == 0) sp = 1; else begin rt = RX; sp = 1; end
      RQ: if (sp < 4) sp++; else begin rt = RF; sp = 0; end
      RL, RA, RN, RS: if (sp < 2) sp++; else begin rt = RC; sp = 0; end
      RJ: begin rt = RC; sp = 0; end
      RZ: if (sp == 0 && z) rt = RJ; else if (sp == 0) sp = 1; else begin rt = RC; sp = 0; end
      default: begin rt = rq ? RQ : RF; sp = 0; end
    endcase
  endtask

  function automatic bit is_noise(input int r, input int s, input logic rq, input logic z);
    return (rq && r != RC) || (z && r != RZ);
  endfunction

  initial begin
    logic [17:0] exp;
    string tag;
    logic prev_irq, prev_zero;
    rst = 1'b1; opcode = '0; ind_bit = 0; zero_flag = 0; irq = 0;
    prev_irq = 0; prev_zero = 0;
    rt = RF; sp = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (rst) begin
        exp = 18'd0; tag = "R1";
      end else begin
        exp = expect_sig(rt, sp);
        tag = req_name(rt, sp);
        if (is_noise(rt, sp, prev_irq, prev_zero)) tag = {tag, " R10"};
      end
      vectors++;
      if (ctrl !== exp) begin
        misses++;
        $display("FAIL %s cycle %0d: ctrl=%05h expected=%05h", tag, cyc, ctrl, exp);
      end
      rst       = (cyc < 3) || (cyc >= 3000 && cyc < 3002);
      opcode    = 3'($urandom % 8);
      ind_bit   = ($urandom % 4) == 0;
      zero_flag = ($urandom % 2) == 0;
      irq       = ($urandom % 5) == 0;
      prev_irq  = irq;
      prev_zero = zero_flag;
      if (rst) begin rt = RF; sp = 0; end
      else advance(opcode, ind_bit, zero_flag, irq);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule